// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

This block carries out coherence maintenance that software requests on a two-level cache model. It keeps the valid, dirty and tag state of three direct-mapped caches: a first-level data cache, a first-level instruction cache and a second-level cache. Software writes a command through a small register port. The block then walks the lines of the affected caches one index per cycle. For each line that has to reach memory it raises a line write-back request on a valid/ready port. It clears valid or dirty bits as the command requires. When the walk ends, the command bit or count register that started it drops back to zero.

There are three kinds of command: invalidate, write-back, and write-back followed by invalidate. Each kind can cover the whole cache or only the lines that overlap a word region given by a base register and a count register. The instruction cache is never written back. An invalidate walks the data cache, then the instruction cache, then the second-level cache. The two write-back kinds walk the data cache and then the second-level cache. Software waits for completion by polling the register it wrote. A fill port installs lines and a probe port looks them up. These two ports stand in for normal cache traffic.

Top module: `cmo_sequencer`

## Requirements
- R1: After reset every line of all three caches misses on the probe port, no write-back request is raised, and registers 0, 2, 3, 4 and 5 read zero.
- R2: Register 0 starts a whole-cache operation. Bit 0 selects invalidate, bit 1 write-back and bit 2 write-back-with-invalidate. While the operation runs, the bit of the running kind reads 1. It reads 0 once the walk is over.
- R3: A whole-cache invalidate clears every valid bit of the data cache, then the instruction cache, then the second-level cache. It raises no memory request, and each invalidated line then misses on the probe.
- R4: A write-back requests exactly the lines that are valid, dirty and in scope. Data-cache lines come before second-level lines, in ascending index order within each cache. Each such line is left valid and clean. Clean lines are left unchanged. The request carries the line's first word address and a source code: 0 for the data cache, 2 for the second-level cache.
- R5: A write-back-with-invalidate requests the same lines as R4 and then leaves every in-scope data-cache and second-level line invalid. Instruction-cache lines are left unchanged.
- R6: A write-back request holds its valid, address and source stable until ready is seen. The line it names still hits on the probe until that handshake completes.
- R7: Register 1 holds a base word address. Writing a non-zero word count to register 2 (invalidate), 3 (write-back) or 4 (write-back-with-invalidate) starts the same operation, limited to the lines whose words overlap [base, base+count). The count register reads that count while the operation runs and 0 otherwise. A zero count starts nothing.
- R8: A start command written while an operation runs is ignored and sets the sticky error bit 0 of register 5. Writing 1 to that bit clears it.
- R9: An operation takes exactly 16 cycles per walked cache plus one cycle for every cycle a request waits on ready, for the default of 16 lines.
- R10: A fill is ignored while an operation runs, and so is a fill whose cache select is 3. Select codes are 0 for the data cache, 1 for the instruction cache and 2 for the second-level cache.
- R11: When several bits of register 0 are written at once, the highest set bit picks the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| fill_en | input | 1 | Install a line |
| fill_sel | input | 2 | Cache select for the fill |
| fill_line | input | ADDR_W-2 | Line address (word address without offset) |
| fill_dirty | input | 1 | Dirty state of the installed line |
| probe_sel | input | 2 | Cache select for the lookup |
| probe_line | input | ADDR_W-2 | Line address to look up |
| probe_hit | output | 1 | Line present and valid |
| probe_dirty | output | 1 | Line present, valid and dirty |
| mem_valid | output | 1 | Line write-back request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | First word address of the line |
| mem_src | output | 2 | Cache the line comes from |

## Verification
The assertions assume that mem_ready may take any value at any time. They assume that at most one register write arrives per cycle, and that line state changes only through the fill port while no operation runs. The bench keeps to these assumptions. Its memory responder is always ready, ready on a pseudo-random pattern, or held low. Fills happen only between operations, except for fills that are meant to be ignored. During a held-low stall the bench sends fills, commands and an invalid cache select on purpose, and checks that they leave the caches unchanged.

// File: rtl/cmo_pkg.sv
`timescale 1ns/1ps
package cmo_pkg;

    typedef enum logic [1:0] {
        CS_L1D = 2'd0,
        CS_L1P = 2'd1,
        CS_L2  = 2'd2
    } cache_e;

    typedef enum logic [1:0] {
        OP_INV = 2'd0,
        OP_WB  = 2'd1,
        OP_WBI = 2'd2
    } op_e;

    localparam logic [2:0] RA_GCMD  = 3'd0;
    localparam logic [2:0] RA_BASE  = 3'd1;
    localparam logic [2:0] RA_C_INV = 3'd2;
    localparam logic [2:0] RA_C_WB  = 3'd3;
    localparam logic [2:0] RA_C_WBI = 3'd4;
    localparam logic [2:0] RA_STAT  = 3'd5;

endpackage

// File: rtl/cmo_line_store.sv
`timescale 1ns/1ps
module cmo_line_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 10,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic [IDX_W-1:0] walk_idx,
    output logic             walk_valid,
    output logic             walk_dirty,
    output logic [TAG_W-1:0] walk_tag,
    input  logic             upd_en,
    input  logic             upd_clr_valid,
    input  logic             upd_clr_dirty,
    input  logic [IDX_W-1:0] probe_idx,
    output logic             probe_valid,
    output logic             probe_dirty,
    output logic [TAG_W-1:0] probe_tag
);

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0]            dirty;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.valid[fill_idx] = 1'b1;
            st_d.dirty[fill_idx] = fill_dirty;
            st_d.tag[fill_idx]   = fill_tag;
        end
        if (upd_en) begin
            if (upd_clr_valid) st_d.valid[walk_idx] = 1'b0;
            if (upd_clr_dirty) st_d.dirty[walk_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign walk_valid  = st_q.valid[walk_idx];
    assign walk_dirty  = st_q.dirty[walk_idx];
    assign walk_tag    = st_q.tag[walk_idx];
    assign probe_valid = st_q.valid[probe_idx];
    assign probe_dirty = st_q.dirty[probe_idx];
    assign probe_tag   = st_q.tag[probe_idx];

    // R4: the sequencer only flushes lines that really hold modified data
    a_r4_flush_only_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_clr_dirty) |-> (st_q.valid[walk_idx] && st_q.dirty[walk_idx]));

    // R10: the fill port and the walker never touch the store in the same cycle
    a_r10_no_fill_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> !fill_en);

endmodule

// File: rtl/cmo_walker.sv
`timescale 1ns/1ps
module cmo_walker
    import cmo_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int LINES          = 16,
    parameter int WORDS_PER_LINE = 4,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS_PER_LINE),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_e               start_op,
    input  logic              start_blk,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [ADDR_W-1:0] start_cnt,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    output logic              busy,
    output op_e               cur_op,
    output logic              cur_blk,
    output logic [ADDR_W-1:0] cur_cnt,
    output cache_e            phase,
    output logic [IDX_W-1:0]  idx,
    output logic              upd_en,
    output logic              clr_valid,
    output logic              clr_dirty,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_src
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);
    localparam int               WCW      = $clog2(3 * LINES) + 1;

    typedef struct packed {
        logic              busy;
        op_e               op;
        logic              blk;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cnt;
        cache_e            phase;
        logic [IDX_W-1:0]  idx;
    } walk_t;

    walk_t wk_q, wk_d;

    logic [ADDR_W-1:0] line_addr;
    logic [ADDR_W:0]   span_lo, span_hi, rgn_lo, rgn_hi;
    logic              in_scope, need_wb, do_inv, step;

    always_comb begin
        line_addr = {line_tag, wk_q.idx, {OFF_W{1'b0}}};
        span_lo   = {1'b0, line_addr};
        span_hi   = span_lo + (ADDR_W+1)'(WORDS_PER_LINE);
        rgn_lo    = {1'b0, wk_q.base};
        rgn_hi    = rgn_lo + {1'b0, wk_q.cnt};
        in_scope  = !wk_q.blk || ((span_lo < rgn_hi) && (span_hi > rgn_lo));

        need_wb = wk_q.busy && (wk_q.op != OP_INV) && (wk_q.phase != CS_L1P)
                  && line_valid && line_dirty && in_scope;
        do_inv  = wk_q.busy && (wk_q.op != OP_WB) && line_valid && in_scope;
        step    = wk_q.busy && (!need_wb || mem_ready);

        wk_d = wk_q;
        if (!wk_q.busy) begin
            if (start) begin
                wk_d.busy  = 1'b1;
                wk_d.op    = start_op;
                wk_d.blk   = start_blk;
                wk_d.base  = start_base;
                wk_d.cnt   = start_cnt;
                wk_d.phase = CS_L1D;
                wk_d.idx   = '0;
            end
        end else if (step) begin
            if (wk_q.idx == LAST_IDX) begin
                wk_d.idx = '0;
                case (wk_q.phase)
                    CS_L1D:  wk_d.phase = (wk_q.op == OP_INV) ? CS_L1P : CS_L2;
                    CS_L1P:  wk_d.phase = CS_L2;
                    default: wk_d.busy  = 1'b0;
                endcase
            end else begin
                wk_d.idx = wk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q       <= '0;
            wk_q.op    <= OP_INV;
            wk_q.phase <= CS_L1D;
        end else begin
            wk_q <= wk_d;
        end
    end

    assign busy      = wk_q.busy;
    assign cur_op    = wk_q.op;
    assign cur_blk   = wk_q.blk;
    assign cur_cnt   = wk_q.cnt;
    assign phase     = wk_q.phase;
    assign idx       = wk_q.idx;
    assign upd_en    = step && (need_wb || do_inv);
    assign clr_valid = do_inv;
    assign clr_dirty = need_wb;
    assign mem_valid = need_wb;
    assign mem_addr  = line_addr;
    assign mem_src   = wk_q.phase;

    // step counter used only by the bound check below
    logic [WCW-1:0] steps_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          steps_q <= '0;
        else if (!wk_q.busy) steps_q <= '0;
        else if (step)       steps_q <= steps_q + 1'b1;
    end

    // R6: a pending write-back request is held until memory takes it
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_src)));

    // R9: no operation walks more than three caches' worth of lines
    a_r9_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (steps_q < WCW'(3 * LINES)));

    // R5: a line is never invalidated while its write-back is still waiting
    a_r5_clear_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |-> !upd_en);

endmodule

// File: rtl/cmo_regs.sv
`timescale 1ns/1ps
module cmo_regs
    import cmo_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              busy,
    input  op_e               cur_op,
    input  logic              cur_blk,
    input  logic [ADDR_W-1:0] cur_cnt,
    output logic              start,
    output op_e               start_op,
    output logic              start_blk,
    output logic [ADDR_W-1:0] start_base,
    output logic [ADDR_W-1:0] start_cnt
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              err;
    } regs_t;

    regs_t rg_q, rg_d;
    logic  cmd_req;

    always_comb begin
        rg_d      = rg_q;
        cmd_req   = 1'b0;
        start_op  = OP_INV;
        start_blk = 1'b0;
        start_cnt = '0;
        if (reg_wr) begin
            case (reg_waddr)
                RA_GCMD: begin
                    if (reg_wdata[2:0] != 3'b000) begin
                        cmd_req = 1'b1;
                        if (reg_wdata[2])      start_op = OP_WBI;
                        else if (reg_wdata[1]) start_op = OP_WB;
                        else                   start_op = OP_INV;
                    end
                end
                RA_BASE: rg_d.base = reg_wdata;
                RA_C_INV, RA_C_WB, RA_C_WBI: begin
                    if (reg_wdata != '0) begin
                        cmd_req   = 1'b1;
                        start_blk = 1'b1;
                        start_cnt = reg_wdata;
                        case (reg_waddr)
                            RA_C_INV: start_op = OP_INV;
                            RA_C_WB:  start_op = OP_WB;
                            default:  start_op = OP_WBI;
                        endcase
                    end
                end
                RA_STAT: if (reg_wdata[0]) rg_d.err = 1'b0;
                default: ;
            endcase
        end
        start = cmd_req && !busy;
        if (cmd_req && busy) rg_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign start_base = rg_q.base;

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            RA_GCMD:  if (busy && !cur_blk) reg_rdata = ADDR_W'(1) << cur_op;
            RA_BASE:  reg_rdata = rg_q.base;
            RA_C_INV: if (busy && cur_blk && cur_op == OP_INV) reg_rdata = cur_cnt;
            RA_C_WB:  if (busy && cur_blk && cur_op == OP_WB)  reg_rdata = cur_cnt;
            RA_C_WBI: if (busy && cur_blk && cur_op == OP_WBI) reg_rdata = cur_cnt;
            RA_STAT:  reg_rdata = {{(ADDR_W-1){1'b0}}, rg_q.err};
            default:  reg_rdata = '0;
        endcase
    end

    // R8: a command that lands while busy raises the error flag
    a_r8_err_on_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && busy) |=> rg_q.err);

    // R8: the flag stays set until software clears it
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.err && !(reg_wr && reg_waddr == RA_STAT && reg_wdata[0])) |=> rg_q.err);

endmodule

// File: rtl/cmo_sequencer.sv
`timescale 1ns/1ps
module cmo_sequencer
    import cmo_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int LINES          = 16,
    parameter int WORDS_PER_LINE = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS_PER_LINE),
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TAG_W  = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_waddr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              fill_en,
    input  logic [1:0]        fill_sel,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_dirty,
    input  logic [1:0]        probe_sel,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit,
    output logic              probe_dirty,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_src
);

    logic              busy, start, start_blk, cur_blk;
    op_e               start_op, cur_op;
    logic [ADDR_W-1:0] start_base, start_cnt, cur_cnt;
    cache_e            phase;
    logic [IDX_W-1:0]  walk_idx;
    logic              upd_en, clr_valid, clr_dirty;
    logic              sel_valid, sel_dirty;
    logic [TAG_W-1:0]  sel_tag;

    logic [2:0]        w_valid, w_dirty, p_valid, p_dirty;
    logic [TAG_W-1:0]  w_tag [3];
    logic [TAG_W-1:0]  p_tag [3];

    cmo_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_waddr  (reg_waddr),
        .reg_wdata  (reg_wdata),
        .reg_raddr  (reg_raddr),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .cur_op     (cur_op),
        .cur_blk    (cur_blk),
        .cur_cnt    (cur_cnt),
        .start      (start),
        .start_op   (start_op),
        .start_blk  (start_blk),
        .start_base (start_base),
        .start_cnt  (start_cnt)
    );

    cmo_walker #(
        .ADDR_W        (ADDR_W),
        .LINES         (LINES),
        .WORDS_PER_LINE(WORDS_PER_LINE)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (start_op),
        .start_blk  (start_blk),
        .start_base (start_base),
        .start_cnt  (start_cnt),
        .line_valid (sel_valid),
        .line_dirty (sel_dirty),
        .line_tag   (sel_tag),
        .busy       (busy),
        .cur_op     (cur_op),
        .cur_blk    (cur_blk),
        .cur_cnt    (cur_cnt),
        .phase      (phase),
        .idx        (walk_idx),
        .upd_en     (upd_en),
        .clr_valid  (clr_valid),
        .clr_dirty  (clr_dirty),
        .mem_valid  (mem_valid),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_src    (mem_src)
    );

    for (genvar c = 0; c < 3; c++) begin : g_cache
        cmo_line_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
            .clk           (clk),
            .rst_n         (rst_n),
            .fill_en       (fill_en && !busy && (fill_sel == 2'(c))),
            .fill_idx      (fill_line[IDX_W-1:0]),
            .fill_tag      (fill_line[LINE_W-1:IDX_W]),
            .fill_dirty    (fill_dirty),
            .walk_idx      (walk_idx),
            .walk_valid    (w_valid[c]),
            .walk_dirty    (w_dirty[c]),
            .walk_tag      (w_tag[c]),
            .upd_en        (upd_en && (phase == cache_e'(c))),
            .upd_clr_valid (clr_valid),
            .upd_clr_dirty (clr_dirty),
            .probe_idx     (probe_line[IDX_W-1:0]),
            .probe_valid   (p_valid[c]),
            .probe_dirty   (p_dirty[c]),
            .probe_tag     (p_tag[c])
        );
    end

    always_comb begin
        case (phase)
            CS_L1D: begin
                sel_valid = w_valid[0]; sel_dirty = w_dirty[0]; sel_tag = w_tag[0];
            end
            CS_L1P: begin
                sel_valid = w_valid[1]; sel_dirty = w_dirty[1]; sel_tag = w_tag[1];
            end
            default: begin
                sel_valid = w_valid[2]; sel_dirty = w_dirty[2]; sel_tag = w_tag[2];
            end
        endcase
    end

    always_comb begin
        probe_hit   = 1'b0;
        probe_dirty = 1'b0;
        for (int c = 0; c < 3; c++) begin
            if (probe_sel == 2'(c) && p_valid[c] && p_tag[c] == probe_line[LINE_W-1:IDX_W]) begin
                probe_hit   = 1'b1;
                probe_dirty = p_dirty[c];
            end
        end
    end

    // R4: the instruction cache never appears as a write-back source
    a_r4_no_code_flush: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_src != 2'd1));

endmodule

// File: tb/cmo_sequencer_test.sv
`timescale 1ns/1ps
module cmo_sequencer_test;

    localparam int AW = 16;
    localparam int NL = 16;
    localparam int LW = AW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_waddr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [2:0]    reg_raddr = '0;
    logic [AW-1:0] reg_rdata;
    logic          fill_en = 1'b0;
    logic [1:0]    fill_sel = '0;
    logic [LW-1:0] fill_line = '0;
    logic          fill_dirty = 1'b0;
    logic [1:0]    probe_sel = '0;
    logic [LW-1:0] probe_line = '0;
    logic          probe_hit, probe_dirty;
    logic          mem_valid;
    logic          mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_src;

    cmo_sequencer #(.ADDR_W(AW), .LINES(NL), .WORDS_PER_LINE(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .fill_en(fill_en), .fill_sel(fill_sel), .fill_line(fill_line), .fill_dirty(fill_dirty),
        .probe_sel(probe_sel), .probe_line(probe_line),
        .probe_hit(probe_hit), .probe_dirty(probe_dirty),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_src(mem_src)
    );

    int mv [3][NL];
    int md [3][NL];
    int mt [3][NL];
    int exp_q [$];
    int checks = 0, fails = 0, stalls = 0, ncyc = 0, rmode = 0, t0 = 0;
    bit done_f = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) ncyc++;

    // memory responder: ready changes shortly after each rising edge
    always @(posedge clk) begin
        #1;
        case (rmode)
            0:       mem_ready = 1'b1;
            1:       mem_ready = 1'($urandom_range(0, 1));
            default: mem_ready = 1'b0;
        endcase
    end

    task automatic check(string req, int act, int expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // compare each handshake against the model's ordered request list (R4, R5)
    always @(negedge clk) begin
        if (rst_n && mem_valid) begin
            if (mem_ready) begin
                if (exp_q.size() == 0) check("R4 unexpected request", {mem_src, mem_addr}, -1);
                else check("R4 request order", {14'd0, mem_src, mem_addr}, exp_q.pop_front());
            end else begin
                stalls++;
            end
        end
    end

    task automatic reg_write(int a, int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 3'(a); reg_wdata = AW'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int a, output int v);
        reg_raddr = 3'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic fill(int c, int tag, int i, int dirty, int upd);
        @(negedge clk);
        fill_en = 1'b1; fill_sel = 2'(c); fill_line = LW'((tag << 4) | i); fill_dirty = 1'(dirty);
        @(negedge clk);
        fill_en = 1'b0;
        if (upd != 0 && c < 3) begin
            mv[c][i] = 1; md[c][i] = dirty; mt[c][i] = tag;
        end
    endtask

    task automatic model_op(int op, int blk, int base, int cnt);
        int order [$];
        if (op == 0) order = '{0, 1, 2};
        else         order = '{0, 2};
        for (int k = 0; k < order.size(); k++) begin
            int c = order[k];
            for (int i = 0; i < NL; i++) begin
                int a = (mt[c][i] << 6) | (i << 2);
                bit inr = (blk == 0) || ((a < base + cnt) && (a + 4 > base));
                if (op != 0 && c != 1 && mv[c][i] != 0 && md[c][i] != 0 && inr) begin
                    exp_q.push_back((c << 16) | a);
                    md[c][i] = 0;
                end
                if (op != 1 && mv[c][i] != 0 && inr) mv[c][i] = 0;
            end
        end
    endtask

    task automatic start_op(int op, int blk, int base, int cnt, int wval);
        model_op(op, blk, base, cnt);
        stalls = 0;
        if (blk != 0) begin
            reg_write(1, base);
            reg_write(2 + op, cnt);
        end else begin
            reg_write(0, wval);
        end
        t0 = ncyc;
    endtask

    task automatic finish_op(int rreg, int first_exp, int phases, string req);
        int v;
        int guard = 0;
        reg_read(rreg, v);
        if (first_exp >= 0) check(req, v, first_exp);
        while (v != 0 && guard < 5000) begin
            @(negedge clk);
            reg_read(rreg, v);
            guard++;
        end
        check("R2 done bit cleared", v, 0);
        check("R9 cycle count", ncyc - t0, phases * NL + stalls);
        check("R4 all requests seen", exp_q.size(), 0);
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < NL; i++) begin
                probe_sel = 2'(c);
                probe_line = LW'((mt[c][i] << 4) | i);
                #1;
                check(req, int'(probe_hit), mv[c][i]);
                check(req, int'(probe_dirty), (mv[c][i] != 0 && md[c][i] != 0) ? 1 : 0);
            end
        end
    endtask

    task automatic random_fill();
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < NL; i++)
                if ($urandom_range(0, 2) != 0)
                    fill(c, int'($urandom_range(0, 1023)), i, int'($urandom_range(0, 1)), 1);
    endtask

    task automatic fixed_fill(int tag);
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < NL - 1; i++)
                fill(c, tag, i, (i % 3 == 0) ? 0 : 1, 1);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_f) begin
            fails++;
            $display("FAIL watchdog expired before the run finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v, a;
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < NL; i++) begin
                mv[c][i] = 0; md[c][i] = 0; mt[c][i] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_read(0, v); check("R1 global reg", v, 0);
        reg_read(3, v); check("R1 count reg", v, 0);
        reg_read(5, v); check("R1 status reg", v, 0);
        check("R1 no request", int'(mem_valid), 0);
        check_all("R1 probe after reset");

        // R2 R4: whole-cache write-back, always ready
        random_fill();
        start_op(1, 0, 0, 0, 2);
        finish_op(0, 2, 2, "R2 busy bit wb");
        check_all("R4 state after write-back");

        // R5: whole-cache write-back-invalidate with random stalls
        random_fill();
        rmode = 1;
        start_op(2, 0, 0, 0, 4);
        finish_op(0, 4, 2, "R2 busy bit wbinv");
        rmode = 0;
        check_all("R5 state after wbinv");

        // R3: whole-cache invalidate touches all three caches
        random_fill();
        start_op(0, 0, 0, 0, 1);
        finish_op(0, 1, 3, "R2 busy bit inv");
        check_all("R3 state after invalidate");

        // R11: several bits set, highest wins (bits 0 and 1 -> write-back)
        random_fill();
        start_op(1, 0, 0, 0, 3);
        finish_op(0, 2, 2, "R11 priority");
        check_all("R11 state");

        // R7: block write-back over an unaligned region
        fixed_fill(5);
        start_op(1, 1, 'h146, 9, 0);
        finish_op(3, 9, 2, "R7 count readback wb");
        check_all("R7 block write-back");

        // R7: block write-back-invalidate with stalls
        rmode = 1;
        start_op(2, 1, 'h157, 20, 0);
        finish_op(4, 20, 2, "R7 count readback wbinv");
        rmode = 0;
        check_all("R7 block wbinv");

        // R7: block invalidate across a line boundary
        start_op(0, 1, 'h15F, 2, 0);
        finish_op(2, 2, 3, "R7 count readback inv");
        check_all("R7 block invalidate");

        // R7: zero count starts nothing
        reg_write(3, 0);
        reg_read(3, v); check("R7 zero count idle", v, 0);
        reg_read(0, v); check("R7 zero count no global", v, 0);
        reg_read(5, v); check("R7 zero count no error", v, 0);

        // R6 R8 R10: stalled wbinv, activity while busy
        fixed_fill(9);
        rmode = 2;
        start_op(2, 0, 0, 0, 4);
        begin
            int guard = 0;
            while (!mem_valid && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        probe_sel = mem_src;
        probe_line = mem_addr[AW-1:2];
        #1;
        check("R6 line valid before handshake", int'(probe_hit), 1);
        check("R6 line dirty before handshake", int'(probe_dirty), 1);
        a = int'(mem_addr);
        repeat (3) @(negedge clk);
        check("R6 request held", int'(mem_valid), 1);
        check("R6 address held", int'(mem_addr), a);
        fill(1, 9, 15, 0, 0);
        fill(3, 9, 15, 1, 0);
        reg_write(0, 1);
        reg_write(2, 5);
        reg_read(5, v); check("R8 error set", v, 1);
        rmode = 0;
        finish_op(0, -1, 2, "R5");
        check_all("R10 fills ignored while busy");

        // R10: invalid select ignored while idle
        fill(3, 9, 15, 1, 0);
        check_all("R10 select 3 ignored");

        // R8: sticky until cleared
        reg_read(5, v); check("R8 error sticky", v, 1);
        reg_write(5, 1);
        reg_read(5, v); check("R8 error cleared", v, 0);

        done_f = 1;
        summary();
        $finish;
    end

endmodule